// File: doc/BRIEF.md
# Debug Port Lock Controller

This block decides, once after every brown-out reset, whether an on-chip debug port may be used. It reads two 16-bit signature words from nonvolatile memory over a registered word-read port. From those two words it settles on one of three policies. The port may be left open. It may be permanently fused shut, with no recovery through this block. Or it may be held shut until a matching password arrives. In the password policy the second signature word also gives the password length in words.

In the password policy a debugger streams words into a mailbox. The attempt opens with a two-word header. The password words follow, one per word position. The block fetches the stored copy of each word from memory and compares it with the received word. The port opens only if every position matches. Any mismatch abandons the attempt, and the next attempt must start with a new header. The result is reported as a debug-enable line and a two-bit lock code. Signatures written after boot have no effect until the next reset.

Top module: `dbg_lock_ctrl`

## Requirements
- R1: After reset is released, the block reads byte address 0xFF80 (first signature) and then 0xFF82 (second signature) on consecutive cycles. Until its decision is made, `dbg_en` is 0 and `lock_state` is 2'b01.
- R2: When both signatures are 0x5555, `lock_state` becomes 2'b01 and `dbg_en` stays 0. `mbx_ready` stays 0, so the mailbox can never open the port.
- R3: When the first signature is 0xAAAA and the second is neither 0x0000 nor 0x5555, `lock_state` becomes 2'b10 and `dbg_en` stays 0.
- R4: Any other signature pair gives `lock_state` 2'b00 with `dbg_en` 1.
- R5: A first signature of 0xAAAA with a second signature of 0x0000 or 0x5555 is treated as open: `lock_state` is 2'b00 and `dbg_en` is 1.
- R6: A password attempt begins only after the mailbox words 0xA55A and then 0x1E1E. Words that arrive before 0xA55A are ignored. A second header word other than 0x1E1E returns the block to waiting for 0xA55A.
- R7: Received password word i (counting from 0) is compared with the stored word at byte address 0xFF88 + 2·i. When all words up to the length match, `lock_state` becomes 2'b11 and `dbg_en` becomes 1. Both then hold until reset.
- R8: A mismatch at any position leaves `lock_state` at 2'b10 and `dbg_en` at 0. Password words sent after that without a fresh header do not open the port.
- R9: Signatures are sampled only after reset. Changing the memory afterwards leaves the outputs unchanged until reset is applied again.
- R10: A mailbox word is taken on a clock edge where both `mbx_valid` and `mbx_ready` are 1. `mbx_ready` is 1 only while the port is password-locked and the block is waiting for a header or a password word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low brown-out reset, asynchronous |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| mbx_valid | input | 1 | Mailbox word present |
| mbx_data | input | 16 | Mailbox word |
| mbx_ready | output | 1 | Block accepts a mailbox word |
| dbg_en | output | 1 | Debug port enabled |
| lock_state | output | 2 | 00 open, 01 fused or booting, 10 password-locked, 11 password accepted |

## Verification
The bench sweeps every pair drawn from a set of signature values that includes both lock keys, zero and ordinary numbers. Sweeping pairs catches a decoder that tests only one signature word and so fuses or locks on a single 0x5555 or 0xAAAA. It also catches a zero-length or 0x5555-length password that is not treated as open, which would leave a port that can never be unlocked. For password lengths 1 to 4 it places a wrong word at each position in turn. That exposes a comparator that checks only the first or last word, or that fetches the stored word for the wrong position. It also replays password words without a header after a failure, and a block that resumed the old attempt would open. Rewriting memory after boot and then resetting checks that signatures are latched only once, at reset.

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] SIG1_ADDR = 'hFF80,
  parameter logic [AW-1:0] SIG2_ADDR = 'hFF82,
  parameter logic [AW-1:0] PW_BASE   = 'hFF88,
  parameter logic [DW-1:0] FUSE_KEY  = 'h5555,
  parameter logic [DW-1:0] PW_KEY    = 'hAAAA,
  parameter logic [DW-1:0] HDR_FIRST = 'hA55A,
  parameter logic [DW-1:0] HDR_SECOND = 'h1E1E
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mbx_valid,
  input  logic [DW-1:0] mbx_data,
  output logic          mbx_ready,
  output logic          dbg_en,
  output logic [1:0]    lock_state
);

  typedef enum logic [3:0] {
    ST_SIG1, ST_SIG2, ST_DECIDE, ST_OPEN, ST_FUSED,
    ST_HDR1, ST_HDR2, ST_WORD, ST_FETCH, ST_CMP, ST_GRANT
  } st_t;

  st_t           st;
  logic [DW-1:0] sig1_q, pw_len, held, idx;
  logic [DW-1:0] idx_nxt;
  logic          xfer;

  assign idx_nxt   = idx + DW'(1);
  assign mbx_ready = (st == ST_HDR1) || (st == ST_HDR2) || (st == ST_WORD);
  assign xfer      = mbx_valid && mbx_ready;
  assign mem_rd    = (st == ST_SIG1) || (st == ST_SIG2) || (st == ST_FETCH);
  assign mem_addr  = (st == ST_SIG1) ? SIG1_ADDR :
                     (st == ST_SIG2) ? SIG2_ADDR :
                     PW_BASE + AW'({idx, 1'b0});
  assign dbg_en    = (st == ST_OPEN) || (st == ST_GRANT);

  always_comb begin
    case (st)
      ST_OPEN:  lock_state = 2'b00;
      ST_GRANT: lock_state = 2'b11;
      ST_HDR1, ST_HDR2, ST_WORD, ST_FETCH, ST_CMP: lock_state = 2'b10;
      default:  lock_state = 2'b01;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_SIG1;
      sig1_q <= '0;
      pw_len <= '0;
      held   <= '0;
      idx    <= '0;
    end else begin
      case (st)
        ST_SIG1: st <= ST_SIG2;
        ST_SIG2: begin
          sig1_q <= mem_rdata;
          st     <= ST_DECIDE;
        end
        ST_DECIDE: begin
          pw_len <= mem_rdata;
          idx    <= '0;
          if (sig1_q == FUSE_KEY && mem_rdata == FUSE_KEY)
            st <= ST_FUSED;
          else if (sig1_q == PW_KEY && mem_rdata != '0 && mem_rdata != FUSE_KEY)
            st <= ST_HDR1;
          else
            st <= ST_OPEN;
        end
        ST_HDR1: if (xfer && mbx_data == HDR_FIRST) st <= ST_HDR2;
        ST_HDR2: if (xfer) begin
          idx <= '0;
          st  <= (mbx_data == HDR_SECOND) ? ST_WORD : ST_HDR1;
        end
        ST_WORD: if (xfer) begin
          held <= mbx_data;
          st   <= ST_FETCH;
        end
        ST_FETCH: st <= ST_CMP;
        ST_CMP: begin
          if (mem_rdata != held) begin
            idx <= '0;
            st  <= ST_HDR1;
          end else if (idx_nxt == pw_len) begin
            st <= ST_GRANT;
          end else begin
            idx <= idx_nxt;
            st  <= ST_WORD;
          end
        end
        default: st <= st;
      endcase
    end
  end

endmodule

module dbg_lock_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          mbx_ready,
  input logic          dbg_en,
  input logic [1:0]    lock_state
);

  p_boot_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr == AW'('hFF82) && lock_state == 2'b01)
      |-> ($past(mem_rd) && $past(mem_addr) == AW'('hFF80)));

  p_fused_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 2'b01 && !mem_rd && $past(lock_state) == 2'b01 && !$past(mem_rd))
      |=> (lock_state == 2'b01 && !dbg_en));

  p_en_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en |-> (lock_state == 2'b00 || lock_state == 2'b11));

  p_grant_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 2'b11) |=> (lock_state == 2'b11 && dbg_en));

  p_grant_from_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_state == 2'b11) |-> ($past(lock_state) == 2'b10));

  p_ready_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_ready |-> (!mem_rd && lock_state == 2'b10 && !dbg_en));

endmodule

bind dbg_lock_ctrl dbg_lock_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dbg_lock_ctrl.sv
module sim_dbg_lock_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        mbx_valid = 0;
  logic [15:0] mbx_data = '0;
  logic        mbx_ready;
  logic        dbg_en;
  logic [1:0]  lock_state;

  logic [15:0] mem [0:63];
  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd && mem_addr[15:7] == 9'h1FF) mem_rdata <= mem[mem_addr[6:1]];
    else mem_rdata <= '0;
  end

  dbg_lock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mbx_valid(mbx_valid), .mbx_data(mbx_data),
    .mbx_ready(mbx_ready), .dbg_en(dbg_en), .lock_state(lock_state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_sigs(input logic [15:0] s1, input logic [15:0] s2);
    mem[0] = s1;
    mem[1] = s2;
  endtask

  function automatic logic [15:0] pw_word(input int len, input int i);
    return 16'(len * 16'h1357 + i * 16'h0F0F + 16'h0101);
  endfunction

  task automatic boot(input bit check_r1);
    mbx_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    if (check_r1) begin
      chk("R1 first addr", {mem_rd, mem_addr}, {1'b1, 16'hFF80});
      chk("R1 boot lock", {dbg_en, lock_state}, {1'b0, 2'b01});
    end
    rst_n = 1;
    @(negedge clk);
    if (check_r1) begin
      chk("R1 second addr", {mem_rd, mem_addr}, {1'b1, 16'hFF82});
      chk("R1 boot lock2", {dbg_en, lock_state}, {1'b0, 2'b01});
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    int n = 0;
    while (!mbx_ready && n < 20) begin
      @(negedge clk);
      n++;
    end
    if (!mbx_ready) begin
      chk("R10 ready never rose", 0, 1);
      return;
    end
    mbx_valid = 1;
    mbx_data = w;
    @(negedge clk);
    mbx_valid = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic send_pw(input int len, input int bad_pos);
    for (int i = 0; i < len; i++)
      send((i == bad_pos) ? ~pw_word(len, i) : pw_word(len, i));
    settle();
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=%0d expected<100000", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h5555, 16'hAAAA, 16'h0004, 16'h1234, 16'hFFFF};
    for (int i = 0; i < 64; i++) mem[i] = '0;

    set_sigs(16'h0000, 16'h0000);
    boot(1);

    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        logic [1:0] exp_ls;
        string tag;
        set_sigs(vals[a], vals[b]);
        boot(0);
        if (vals[a] == 16'h5555 && vals[b] == 16'h5555) begin
          exp_ls = 2'b01; tag = "R2 fused";
        end else if (vals[a] == 16'hAAAA && vals[b] != 16'h0000 && vals[b] != 16'h5555) begin
          exp_ls = 2'b10; tag = "R3 pw-locked";
        end else if (vals[a] == 16'hAAAA) begin
          exp_ls = 2'b00; tag = "R5 bad length open";
        end else begin
          exp_ls = 2'b00; tag = "R4 open";
        end
        chk(tag, {vals[a], vals[b], dbg_en, lock_state},
            {vals[a], vals[b], exp_ls == 2'b00, exp_ls});
        chk("R10 ready by mode", {vals[a], vals[b], mbx_ready},
            {vals[a], vals[b], exp_ls == 2'b10});
      end
    end

    // R2: fused port ignores a full mailbox attempt
    set_sigs(16'h5555, 16'h5555);
    boot(0);
    mbx_valid = 1; mbx_data = 16'hA55A;
    repeat (3) @(negedge clk);
    mbx_data = 16'h1E1E;
    repeat (3) @(negedge clk);
    mbx_valid = 0;
    chk("R2 mailbox ignored", {mbx_ready, dbg_en, lock_state}, {1'b0, 1'b0, 2'b01});

    for (int len = 1; len <= 4; len++) begin
      for (int i = 0; i < len; i++) mem[4 + i] = pw_word(len, i);
      set_sigs(16'hAAAA, 16'(len));

      boot(0);
      send(pw_word(len, 0));
      send(16'h1E1E);
      settle();
      chk("R6 words before header ignored", {dbg_en, lock_state}, {1'b0, 2'b10});
      send(16'hA55A);
      send(16'h0000);
      send_pw(len, -1);
      chk("R6 bad second header restarts", {dbg_en, lock_state}, {1'b0, 2'b10});
      send(16'hA55A);
      send(16'h1E1E);
      send_pw(len, -1);
      chk("R7 correct password grants", {len[7:0], dbg_en, lock_state}, {len[7:0], 1'b1, 2'b11});
      settle();
      chk("R7 grant holds", {mbx_ready, dbg_en, lock_state}, {1'b0, 1'b1, 2'b11});

      for (int p = 0; p < len; p++) begin
        boot(0);
        send(16'hA55A);
        send(16'h1E1E);
        send_pw(len, p);
        chk("R8 mismatch keeps lock", {len[7:0], p[7:0], dbg_en, lock_state},
            {len[7:0], p[7:0], 1'b0, 2'b10});
        send_pw(len, -1);
        chk("R8 no resume without header", {len[7:0], p[7:0], dbg_en, lock_state},
            {len[7:0], p[7:0], 1'b0, 2'b10});
        send(16'hA55A);
        send(16'h1E1E);
        send_pw(len, -1);
        chk("R8 fresh header retries", {len[7:0], p[7:0], dbg_en, lock_state},
            {len[7:0], p[7:0], 1'b1, 2'b11});
      end
    end

    // R9: signatures latched only at reset
    set_sigs(16'h0000, 16'h0000);
    boot(0);
    set_sigs(16'h5555, 16'h5555);
    repeat (10) @(negedge clk);
    chk("R9 change ignored before reset", {dbg_en, lock_state}, {1'b1, 2'b00});
    boot(0);
    chk("R9 change applied after reset", {dbg_en, lock_state}, {1'b0, 2'b01});
    set_sigs(16'h0000, 16'h0000);
    repeat (10) @(negedge clk);
    chk("R9 unfuse waits for reset", {dbg_en, lock_state}, {1'b0, 2'b01});
    boot(0);
    chk("R9 zeros reopen after reset", {dbg_en, lock_state}, {1'b1, 2'b00});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule